// File: doc/BRIEF.md
# Byte-Lane Asynchronous SRAM Port Controller

This block sits between a clocked host and an external asynchronous static RAM that is 16 bits wide, split into two byte lanes. The host hands over one request at a time through a valid/ready handshake: a direction, a 17-bit word address, write data and a two-bit lane mask. The controller turns the request into registered, active-low chip, output and write enables, per-lane byte strobes and a tri-state data bus. The bus is represented as separate in, out and drive-enable signals. A read returns its data with a one-cycle done pulse. A write also reports its completion with a done pulse.

Pulse widths are counted in clock cycles. Three nanosecond parameters, for the write pulse, the data setup and the read access, are each rounded up to whole clock periods, with a floor of one cycle. A write is always ended by the byte strobes rising while write enable stays low. This lets a following write reuse the low write enable and pulse only the strobes. The controller never drives the data bus while the memory may drive it. It inserts a dead cycle whenever the direction of the bus could flip between two consecutive accesses.

Top module: `asram_port`

## Requirements
- R1: After reset, and in every cycle with no access in progress, chip enable, output enable, write enable and both byte strobes are high (inactive), the data bus is not driven, and `req_ready` is high.
- R2: A read drives chip enable and output enable low and write enable high, presents the address, and holds this for RD_C = max(1, ceil(RD_NS/CLK_NS)) cycles. The done pulse appears RD_C cycles after the accepting clock edge, plus one more cycle if a turnaround is inserted.
- R3: Mask bit 0 selects data bits 7:0 and drives byte strobe bit 0. Mask bit 1 selects bits 15:8 and drives byte strobe bit 1. Strobe bit n is low during an access exactly when mask bit n is 1. Read data on a lane whose mask bit is 0 is returned as zero.
- R4: A write drives chip enable and write enable low and output enable high, drives the write data onto the bus, and holds the address, the data and the strobes for WR_C = max(ceil(WE_NS/CLK_NS), ceil(SU_NS/CLK_NS), 1) cycles. The done pulse appears WR_C cycles after the accepting edge, plus one if a turnaround is inserted.
- R5: A write ends with the byte strobes rising first. In the done cycle the strobes are high while chip enable and write enable are still low and the data is still driven. If no write follows, every control is inactive in the next cycle.
- R6: A write accepted in the done cycle of the previous write starts without a rising edge on write enable. Only the byte strobes pulse again, with the new address and data.
- R7: A write accepted after a read (with no write in between) is preceded by one cycle with every control inactive.
- R8: A read accepted in the done cycle of a write is preceded by one cycle with every control inactive. A read accepted later starts at once.
- R9: The data bus is driven only while write enable is low and output enable is high.
- R10: `req_ready` is high only when no access is in progress or in a write's done cycle. `rsp_valid` is a single-cycle pulse.
- R11: A write whose mask is 0 pulls no strobe low and leaves memory unchanged. A read whose mask is 0 returns zero.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous reset, active low |
| req_valid | input | 1 | Host request present |
| req_ready | output | 1 | Controller can accept a request this cycle |
| req_write | input | 1 | 1 = write, 0 = read |
| req_addr | input | 17 | Word address |
| req_wdata | input | 16 | Write data |
| req_mask | input | 2 | Lane mask, bit 0 = bits 7:0, bit 1 = bits 15:8 |
| rsp_valid | output | 1 | One-cycle completion pulse |
| rsp_rdata | output | 16 | Read data, valid with `rsp_valid` after a read |
| sram_ce_n | output | 1 | Chip enable, active low |
| sram_oe_n | output | 1 | Output enable, active low |
| sram_we_n | output | 1 | Write enable, active low |
| sram_bs_n | output | 2 | Byte strobes, active low, bit 0 = lower lane |
| sram_addr | output | 17 | Memory address |
| sram_dq_o | output | 16 | Data driven to the memory |
| sram_dq_oe | output | 1 | Drive enable for `sram_dq_o` |
| sram_dq_i | input | 16 | Data read from the memory |

## Verification
All pins are registered. The first access pattern therefore shows on the pins in the cycle right after the accepting edge, or one cycle later when a turnaround is due. The done pulse comes RD_C or WR_C edges after the pins go active. The bench sets the three timing parameters so that RD_C is 2 and WR_C is 3, making the latencies distinct. At each accept it computes the due cycle from the requirement formulas and from its own record of whether a turnaround applies. The monitor then compares the free-running cycle count at the done pulse with that value. Pin patterns are sampled on the falling edge of the first turnaround or access cycle, and in the done cycle. A pin-level memory model in the bench commits a lane only when that lane's strobe window closes, so read-back values also show whether the strobe sequencing is correct.

// File: rtl/asram_pkg.sv
package asram_pkg;

    typedef enum logic [2:0] {
        ST_IDLE,
        ST_TURN,
        ST_RD,
        ST_WR,
        ST_WEND
    } asram_st_e;

endpackage

// File: rtl/asram_wait_cnt.sv
module asram_wait_cnt #(
    parameter int CNT_W = 2
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             load,
    input  logic [CNT_W-1:0] load_val,
    output logic             last
);

    logic [CNT_W-1:0] cnt_d, cnt_q;

    always_comb begin
        cnt_d = cnt_q;
        if (load) begin
            cnt_d = load_val;
        end else if (cnt_q != '0) begin
            cnt_d = cnt_q - 1'b1;
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) cnt_q <= '0;
        else        cnt_q <= cnt_d;
    end

    // the final cycle of a loaded window
    assign last = (cnt_q == CNT_W'(1));

endmodule

// File: rtl/asram_lane_ctl.sv
module asram_lane_ctl #(
    parameter int LANES = 2
) (
    input  logic [LANES-1:0]   mask,
    input  logic [LANES*8-1:0] dq_in,
    output logic [LANES-1:0]   bs_n,
    output logic [LANES*8-1:0] rd_lanes
);

    for (genvar g = 0; g < LANES; g++) begin : g_lane
        assign bs_n[g]           = ~mask[g];
        assign rd_lanes[g*8 +: 8] = mask[g] ? dq_in[g*8 +: 8] : 8'h00;
    end

endmodule

// File: rtl/asram_port.sv
module asram_port
    import asram_pkg::*;
#(
    parameter int ADDR_W = 17,
    parameter int DATA_W = 16,
    parameter int CLK_NS = 10,
    parameter int WE_NS  = 8,
    parameter int SU_NS  = 6,
    parameter int RD_NS  = 10
) (
    input  logic                clk,
    input  logic                rst_n,
    input  logic                req_valid,
    output logic                req_ready,
    input  logic                req_write,
    input  logic [ADDR_W-1:0]   req_addr,
    input  logic [DATA_W-1:0]   req_wdata,
    input  logic [DATA_W/8-1:0] req_mask,
    output logic                rsp_valid,
    output logic [DATA_W-1:0]   rsp_rdata,
    output logic                sram_ce_n,
    output logic                sram_oe_n,
    output logic                sram_we_n,
    output logic [DATA_W/8-1:0] sram_bs_n,
    output logic [ADDR_W-1:0]   sram_addr,
    output logic [DATA_W-1:0]   sram_dq_o,
    output logic                sram_dq_oe,
    input  logic [DATA_W-1:0]   sram_dq_i
);

    localparam int LANES  = DATA_W / 8;
    localparam int WE_RAW = (WE_NS + CLK_NS - 1) / CLK_NS;
    localparam int SU_RAW = (SU_NS + CLK_NS - 1) / CLK_NS;
    localparam int RD_RAW = (RD_NS + CLK_NS - 1) / CLK_NS;
    localparam int WE_C   = (WE_RAW < 1) ? 1 : WE_RAW;
    localparam int SU_C   = (SU_RAW < 1) ? 1 : SU_RAW;
    localparam int RD_C   = (RD_RAW < 1) ? 1 : RD_RAW;
    localparam int WR_C   = (WE_C > SU_C) ? WE_C : SU_C;
    localparam int MAX_C  = (WR_C > RD_C) ? WR_C : RD_C;
    localparam int CNT_W  = $clog2(MAX_C + 1);

    typedef struct packed {
        asram_st_e           st;
        logic                last_rd;
        logic                p_wr;
        logic [ADDR_W-1:0]   addr;
        logic [DATA_W-1:0]   wdata;
        logic [LANES-1:0]    mask;
        logic                ce_n;
        logic                oe_n;
        logic                we_n;
        logic [LANES-1:0]    bs_n;
        logic                dq_oe;
        logic [DATA_W-1:0]   rdata;
        logic                done;
    } port_regs_t;

    port_regs_t r_d, r_q;

    logic             accept;
    logic [LANES-1:0] mask_sel;
    logic [LANES-1:0] lane_bs_n;
    logic [DATA_W-1:0] rd_lanes;
    logic             cnt_load;
    logic [CNT_W-1:0] cnt_val;
    logic             cnt_last;

    assign req_ready = (r_q.st == ST_IDLE) || (r_q.st == ST_WEND);
    assign accept    = req_valid && req_ready;
    assign mask_sel  = accept ? req_mask : r_q.mask;

    asram_lane_ctl #(.LANES(LANES)) lane_i (
        .mask     (mask_sel),
        .dq_in    (sram_dq_i),
        .bs_n     (lane_bs_n),
        .rd_lanes (rd_lanes)
    );

    asram_wait_cnt #(.CNT_W(CNT_W)) wait_i (
        .clk      (clk),
        .rst_n    (rst_n),
        .load     (cnt_load),
        .load_val (cnt_val),
        .last     (cnt_last)
    );

    always_comb begin
        r_d      = r_q;
        r_d.done = 1'b0;
        cnt_load = 1'b0;
        cnt_val  = '0;

        unique case (r_q.st)
            ST_IDLE, ST_WEND: begin
                // default exit: release every control
                r_d.st    = ST_IDLE;
                r_d.ce_n  = 1'b1;
                r_d.oe_n  = 1'b1;
                r_d.we_n  = 1'b1;
                r_d.bs_n  = '1;
                r_d.dq_oe = 1'b0;
                if (accept) begin
                    r_d.p_wr  = req_write;
                    r_d.addr  = req_addr;
                    r_d.wdata = req_wdata;
                    r_d.mask  = req_mask;
                    if (req_write ? r_q.last_rd : (r_q.st == ST_WEND)) begin
                        r_d.st = ST_TURN;
                    end else if (req_write) begin
                        r_d.st      = ST_WR;
                        r_d.ce_n    = 1'b0;
                        r_d.we_n    = 1'b0;
                        r_d.bs_n    = lane_bs_n;
                        r_d.dq_oe   = 1'b1;
                        r_d.last_rd = 1'b0;
                        cnt_load    = 1'b1;
                        cnt_val     = CNT_W'(WR_C);
                    end else begin
                        r_d.st   = ST_RD;
                        r_d.ce_n = 1'b0;
                        r_d.oe_n = 1'b0;
                        r_d.bs_n = lane_bs_n;
                        cnt_load = 1'b1;
                        cnt_val  = CNT_W'(RD_C);
                    end
                end
            end
            ST_TURN: begin
                r_d.ce_n = 1'b0;
                r_d.bs_n = lane_bs_n;
                cnt_load = 1'b1;
                if (r_q.p_wr) begin
                    r_d.st      = ST_WR;
                    r_d.we_n    = 1'b0;
                    r_d.dq_oe   = 1'b1;
                    r_d.last_rd = 1'b0;
                    cnt_val     = CNT_W'(WR_C);
                end else begin
                    r_d.st   = ST_RD;
                    r_d.oe_n = 1'b0;
                    cnt_val  = CNT_W'(RD_C);
                end
            end
            ST_RD: begin
                if (cnt_last) begin
                    r_d.st      = ST_IDLE;
                    r_d.rdata   = rd_lanes;
                    r_d.done    = 1'b1;
                    r_d.last_rd = 1'b1;
                    r_d.ce_n    = 1'b1;
                    r_d.oe_n    = 1'b1;
                    r_d.bs_n    = '1;
                end
            end
            ST_WR: begin
                if (cnt_last) begin
                    // strobes rise first; enables and data held
                    r_d.st   = ST_WEND;
                    r_d.bs_n = '1;
                    r_d.done = 1'b1;
                end
            end
            default: begin
                r_d.st = ST_IDLE;
            end
        endcase
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            r_q         <= '0;
            r_q.st      <= ST_IDLE;
            r_q.ce_n    <= 1'b1;
            r_q.oe_n    <= 1'b1;
            r_q.we_n    <= 1'b1;
            r_q.bs_n    <= '1;
        end else begin
            r_q <= r_d;
        end
    end

    assign rsp_valid  = r_q.done;
    assign rsp_rdata  = r_q.rdata;
    assign sram_ce_n  = r_q.ce_n;
    assign sram_oe_n  = r_q.oe_n;
    assign sram_we_n  = r_q.we_n;
    assign sram_bs_n  = r_q.bs_n;
    assign sram_addr  = r_q.addr;
    assign sram_dq_o  = r_q.wdata;
    assign sram_dq_oe = r_q.dq_oe;

endmodule

// File: rtl/asram_port_chk.sv
module asram_port_chk #(
    parameter int ADDR_W = 17,
    parameter int DATA_W = 16
) (
    input logic                clk,
    input logic                rst_n,
    input logic                req_ready,
    input logic                rsp_valid,
    input logic                sram_ce_n,
    input logic                sram_oe_n,
    input logic                sram_we_n,
    input logic [DATA_W/8-1:0] sram_bs_n,
    input logic [ADDR_W-1:0]   sram_addr,
    input logic [DATA_W-1:0]   sram_dq_o,
    input logic                sram_dq_oe
);

    logic wr_win;
    assign wr_win = !sram_ce_n && !sram_we_n && !(&sram_bs_n);

    assert_deselect_quiet_R1: assert property (@(posedge clk) disable iff (!rst_n)
        sram_ce_n |-> (sram_oe_n && sram_we_n && (&sram_bs_n) && !sram_dq_oe));

    assert_write_oe_high_R4: assert property (@(posedge clk) disable iff (!rst_n)
        !sram_we_n |-> sram_oe_n);

    assert_write_window_stable_R4: assert property (@(posedge clk) disable iff (!rst_n)
        (wr_win && $past(wr_win)) |-> ($stable(sram_addr) && $stable(sram_dq_o) && $stable(sram_bs_n)));

    assert_no_we_after_oe_R7: assert property (@(posedge clk) disable iff (!rst_n)
        !sram_we_n |-> $past(sram_oe_n));

    assert_no_oe_after_we_R8: assert property (@(posedge clk) disable iff (!rst_n)
        !sram_oe_n |-> $past(sram_we_n));

    assert_drive_only_writing_R9: assert property (@(posedge clk) disable iff (!rst_n)
        sram_dq_oe |-> (!sram_we_n && sram_oe_n));

    assert_done_single_R10: assert property (@(posedge clk) disable iff (!rst_n)
        rsp_valid |=> !rsp_valid);

    assert_done_with_ready_R10: assert property (@(posedge clk) disable iff (!rst_n)
        rsp_valid |-> req_ready);

endmodule

bind asram_port asram_port_chk #(
    .ADDR_W (ADDR_W),
    .DATA_W (DATA_W)
) chk_i (
    .clk        (clk),
    .rst_n      (rst_n),
    .req_ready  (req_ready),
    .rsp_valid  (rsp_valid),
    .sram_ce_n  (sram_ce_n),
    .sram_oe_n  (sram_oe_n),
    .sram_we_n  (sram_we_n),
    .sram_bs_n  (sram_bs_n),
    .sram_addr  (sram_addr),
    .sram_dq_o  (sram_dq_o),
    .sram_dq_oe (sram_dq_oe)
);

// File: tb/asram_port_tb_top.sv
module asram_port_tb_top;

    localparam int CLK_PERIOD = 10;
    localparam int AW = 17;
    localparam int DW = 16;
    localparam int WE_NS = 25;
    localparam int SU_NS = 12;
    localparam int RD_NS = 18;
    // expected cycle counts from the R2/R4 formulas
    localparam int RD_C = 2;
    localparam int WR_C = 3;

    logic          clk = 1'b0;
    logic          rst_n = 1'b0;
    logic          req_valid = 1'b0;
    logic          req_ready;
    logic          req_write = 1'b0;
    logic [AW-1:0] req_addr = '0;
    logic [DW-1:0] req_wdata = '0;
    logic [1:0]    req_mask = '0;
    logic          rsp_valid;
    logic [DW-1:0] rsp_rdata;
    logic          sram_ce_n, sram_oe_n, sram_we_n, sram_dq_oe;
    logic [1:0]    sram_bs_n;
    logic [AW-1:0] sram_addr;
    logic [DW-1:0] sram_dq_o, sram_dq_i;

    always #(CLK_PERIOD/2) clk = ~clk;

    asram_port #(.ADDR_W(AW), .DATA_W(DW), .CLK_NS(CLK_PERIOD),
                 .WE_NS(WE_NS), .SU_NS(SU_NS), .RD_NS(RD_NS)) dut_i (
        .clk(clk), .rst_n(rst_n), .req_valid(req_valid), .req_ready(req_ready),
        .req_write(req_write), .req_addr(req_addr), .req_wdata(req_wdata),
        .req_mask(req_mask), .rsp_valid(rsp_valid), .rsp_rdata(rsp_rdata),
        .sram_ce_n(sram_ce_n), .sram_oe_n(sram_oe_n), .sram_we_n(sram_we_n),
        .sram_bs_n(sram_bs_n), .sram_addr(sram_addr), .sram_dq_o(sram_dq_o),
        .sram_dq_oe(sram_dq_oe), .sram_dq_i(sram_dq_i)
    );

    int n_tests = 0;
    int n_fail  = 0;
    int cyc     = 0;
    int we_rise = 0;
    int last_done_cyc = -10;
    bit summary_done = 1'b0;

    function automatic logic [15:0] init_word(input int i);
        return 16'(i * 16'h0101) ^ 16'h8000;
    endfunction

    // pin-level memory model and bench reference
    logic [15:0] mem     [0:63];
    logic [15:0] ref_mem [0:63];
    logic [1:0]  prev_act = 2'b00;
    logic [5:0]  prev_a = '0;
    logic [15:0] prev_d = '0;

    initial begin
        for (int i = 0; i < 64; i++) begin
            mem[i]     = init_word(i);
            ref_mem[i] = init_word(i);
        end
    end

    wire rd_en = !sram_ce_n && !sram_oe_n && sram_we_n;
    assign sram_dq_i = { (rd_en && !sram_bs_n[1]) ? mem[sram_addr[5:0]][15:8] : 8'h5A,
                         (rd_en && !sram_bs_n[0]) ? mem[sram_addr[5:0]][7:0]  : 8'h5A };

    always @(negedge clk) begin
        for (int l = 0; l < 2; l++) begin
            logic act;
            act = !sram_ce_n && !sram_we_n && !sram_bs_n[l];
            if (prev_act[l] && !act) mem[prev_a][l*8 +: 8] = prev_d[l*8 +: 8];
            prev_act[l] = act;
        end
        prev_a = sram_addr[5:0];
        prev_d = sram_dq_o;
    end

    always @(posedge clk) cyc <= cyc + 1;
    always @(posedge sram_we_n) if (rst_n) we_rise++;

    task automatic check(input bit ok, input string req, input logic [31:0] act, input logic [31:0] exp);
        n_tests++;
        if (!ok) begin
            n_fail++;
            $display("FAIL %s actual=%0h expected=%0h (cycle %0d)", req, act, exp, cyc);
        end
    endtask

    task automatic finish_run();
        if (!summary_done) begin
            summary_done = 1'b1;
            $display("  [TB] %0d tests run, %0d failed", n_tests, n_fail);
            $finish;
        end
    endtask

    typedef struct {
        bit          is_rd;
        logic [15:0] exp_data;
        int          exp_cyc;
    } item_t;
    item_t sbq[$];

    // monitor
    always @(negedge clk) begin
        if (rst_n && rsp_valid) begin
            if (sbq.size() == 0) begin
                check(1'b0, "R10 unexpected done", 32'(cyc), 32'hFFFF);
            end else begin
                item_t it;
                it = sbq.pop_front();
                check(cyc == it.exp_cyc, it.is_rd ? "R2 read done cycle" : "R4 write done cycle",
                      32'(cyc), 32'(it.exp_cyc));
                if (it.is_rd) begin
                    check(rsp_rdata == it.exp_data, "R3 read data", 32'(rsp_rdata), 32'(it.exp_data));
                end else begin
                    check(sram_bs_n == 2'b11 && !sram_we_n && !sram_ce_n && sram_dq_oe,
                          "R5 strobes end write",
                          {27'd0, sram_bs_n, sram_we_n, sram_ce_n, sram_dq_oe}, 32'b11001);
                end
            end
            last_done_cyc = cyc;
        end
    end

    bit prev_rd = 1'b0;
    bit prev_wr = 1'b0;

    task automatic do_req(input bit wr, input logic [AW-1:0] a, input logic [15:0] d,
                          input logic [1:0] m, input int gap);
        int A;
        int w0;
        bit imm;
        bit turn;
        item_t it;
        repeat (gap) @(negedge clk);
        while (!req_ready) @(negedge clk);
        req_valid = 1'b1; req_write = wr; req_addr = a; req_wdata = d; req_mask = m;
        w0 = we_rise;
        @(negedge clk);
        req_valid = 1'b0;
        A    = cyc;
        imm  = (A == last_done_cyc + 1);
        turn = wr ? prev_rd : (prev_wr && imm);
        it.is_rd    = !wr;
        it.exp_cyc  = A + int'(turn) + (wr ? WR_C : RD_C);
        it.exp_data = { m[1] ? ref_mem[a[5:0]][15:8] : 8'h00,
                        m[0] ? ref_mem[a[5:0]][7:0]  : 8'h00 };
        sbq.push_back(it);
        if (wr) begin
            if (m[1]) ref_mem[a[5:0]][15:8] = d[15:8];
            if (m[0]) ref_mem[a[5:0]][7:0]  = d[7:0];
        end
        if (turn) begin
            check(sram_ce_n && sram_oe_n && sram_we_n && sram_bs_n == 2'b11 && !sram_dq_oe,
                  wr ? "R7 turnaround before write" : "R8 turnaround before read",
                  {27'd0, sram_ce_n, sram_oe_n, sram_we_n, sram_bs_n}, 32'h1F);
            @(negedge clk);
        end
        check(!req_ready, "R10 busy during access", 32'(req_ready), 0);
        check(sram_addr == a, "R2 R4 address on pins", 32'(sram_addr), 32'(a));
        check(sram_bs_n == ~m, "R3 R11 strobes follow mask", 32'(sram_bs_n), 32'(~m));
        if (wr) begin
            check(!sram_ce_n && !sram_we_n && sram_oe_n && sram_dq_oe && sram_dq_o == d,
                  "R4 write pins", {sram_ce_n, sram_we_n, sram_oe_n, sram_dq_oe, 12'd0, sram_dq_o},
                  {4'b0011, 12'd0, d});
            if (prev_wr && imm)
                check(we_rise == w0, "R6 write enable held low", 32'(we_rise), 32'(w0));
        end else begin
            check(!sram_ce_n && !sram_oe_n && sram_we_n && !sram_dq_oe,
                  "R2 R9 read pins", {28'd0, sram_ce_n, sram_oe_n, sram_we_n, sram_dq_oe}, 32'b0010);
        end
        prev_rd = !wr;
        prev_wr = wr;
    endtask

    task automatic drain();
        int t = 0;
        while (sbq.size() != 0 && t < 100) begin
            @(negedge clk);
            t++;
        end
        check(sbq.size() == 0, "R10 all responses seen", 32'(sbq.size()), 0);
    endtask

    initial begin
        repeat (100000) @(posedge clk);
        check(1'b0, "watchdog expired", 32'(cyc), 0);
        finish_run();
    end

    initial begin
        repeat (3) @(negedge clk);
        check(req_ready && sram_ce_n && sram_oe_n && sram_we_n && sram_bs_n == 2'b11
              && !sram_dq_oe && !rsp_valid, "R1 reset state",
              {25'd0, req_ready, sram_ce_n, sram_oe_n, sram_we_n, sram_bs_n, sram_dq_oe}, 32'h7E);
        rst_n = 1'b1;
        @(negedge clk);
        check(req_ready && sram_ce_n && !sram_dq_oe, "R1 idle after reset",
              {30'd0, req_ready, sram_ce_n}, 32'h3);

        // back-to-back writes: R4, R5, R6
        do_req(1'b1, 17'h00003, 16'hA5C3, 2'b11, 0);
        do_req(1'b1, 17'h00004, 16'h1234, 2'b01, 0);
        do_req(1'b1, 17'h00005, 16'hFFEE, 2'b10, 0);
        // read straight after a write: R8
        do_req(1'b0, 17'h00003, 16'h0000, 2'b11, 0);
        do_req(1'b0, 17'h00004, 16'h0000, 2'b11, 0);
        // write after read: R7
        do_req(1'b1, 17'h00006, 16'h0F0F, 2'b11, 0);
        drain();
        @(negedge clk);
        check(sram_ce_n && sram_we_n && sram_bs_n == 2'b11 && !sram_dq_oe && req_ready,
              "R5 R1 controls released after write",
              {27'd0, sram_ce_n, sram_we_n, sram_bs_n, sram_dq_oe}, 32'b11110);
        // read after a gap: no turnaround (R8)
        do_req(1'b0, 17'h00006, 16'h0000, 2'b11, 3);
        // single-lane reads: R3
        do_req(1'b0, 17'h00005, 16'h0000, 2'b01, 0);
        do_req(1'b0, 17'h00005, 16'h0000, 2'b10, 0);
        // empty mask: R11
        do_req(1'b1, 17'h00007, 16'hBEEF, 2'b00, 0);
        do_req(1'b0, 17'h00007, 16'h0000, 2'b11, 2);
        do_req(1'b0, 17'h00008, 16'h0000, 2'b00, 0);
        // full-width address: R2 R4
        do_req(1'b1, 17'h1FFC9, 16'h7E81, 2'b11, 1);
        do_req(1'b0, 17'h1FFC9, 16'h0000, 2'b11, 0);
        // mixed traffic
        for (int k = 0; k < 6; k++) begin
            do_req(1'b1, 17'(k + 16), 16'(k * 16'h1357 + 16'h0042), 2'(k % 4), k % 2);
            do_req(1'b0, 17'(k + 16), 16'h0000, 2'b11, (k + 1) % 2);
        end
        drain();
        repeat (4) @(negedge clk);
        check(sbq.size() == 0 && !rsp_valid, "R10 no stray responses", 32'(sbq.size()), 0);
        finish_run();
    end

endmodule